// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block is an 8-bit memory-mapped status and enable register that serves three timer channels. Each channel has one event flag and one interrupt-enable bit. The channel's mode input picks which timer event sets its flag. In compare mode, the pulse that reports counter equality with general register A sets the flag. In capture mode, the pulse that reports a counter capture into that register sets it instead.

Software clears a flag with a two-step handshake. It must first read the register and see the flag as 1. It then writes 0 to that flag position. A DMA acknowledge for the channel also clears the flag. Writing 1 never sets a flag.

Each channel drives an interrupt request. That request is high while both the channel's flag and its enable bit are 1, and the channel's DMA trigger follows the same condition. All state is synchronous to `clk_i`, with an active-low asynchronous reset.

Top module: `tmr_irq_flag_reg`

## Requirements
- R1: After reset the register reads 0x88: all enables and all flags are 0, and `irq_o` and `dma_req_o` are 0.
- R2: Bits 7 and 3 always read as 1, and writes to them have no effect.
- R3: Bits 6, 5 and 4 are the interrupt enables of channels 2, 1 and 0. They are plain read/write and take the written value at the write's clock edge.
- R4: Bits 2, 1 and 0 are the flags of channels 2, 1 and 0. Writing 1 to a flag bit never sets it.
- R5: Writing 0 to a flag leaves the flag at 1 unless an earlier read, with no write in between, returned that flag as 1.
- R6: After a read returns a flag as 1, the next write clears that flag if the written bit is 0. Any write consumes the armed read, so a later 0 written without a fresh read leaves the flag set.
- R7: With `mode_i[i]`=0 (compare), a `match_i[i]` pulse sets flag i. A `capt_i[i]` pulse has no effect.
- R8: With `mode_i[i]`=1 (capture), a `capt_i[i]` pulse sets flag i. A `match_i[i]` pulse has no effect.
- R9: `irq_o[i]` is 1 exactly while flag i and enable i are both 1.
- R10: A `dma_ack_i[i]` pulse clears flag i. `dma_req_o[i]` equals `irq_o[i]`.
- R11: When a set event and a clear (software or DMA) for the same channel fall in one cycle, the flag ends at 1.
- R12: `rdata_o` is 0 whenever `sel_i && rd_i` is low. During a read access it shows the register value held before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when no read access |
| mode_i | input | 3 | Per-channel mode: 0 compare, 1 capture |
| match_i | input | 3 | Per-channel compare-equality pulse |
| capt_i | input | 3 | Per-channel capture pulse |
| dma_ack_i | input | 3 | Per-channel DMA acknowledge pulse |
| irq_o | output | 3 | Per-channel interrupt request |
| dma_req_o | output | 3 | Per-channel DMA trigger |

## Verification
Read data is combinational, so the bench samples `rdata_o` one nanosecond after it drives a read access. That sample comes before the edge that registers the access. Flags, enables and the armed-read state all update at the next rising edge, so `irq_o` and `dma_req_o` reflect an event, write or acknowledge one cycle after it is driven. The bench updates its reference model at that same edge and compares the outputs just after it. Inputs always change at the falling edge, so every comparison falls half a cycle away from any change.

// File: rtl/tifr_pkg.sv
package tifr_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } bus_acc_t;

  localparam logic RSVD_VAL = 1'b1;
endpackage

// File: rtl/tifr_chan.sv
module tifr_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_cap_i,
  input  logic match_i,
  input  logic capt_i,
  input  logic dma_ack_i,
  input  logic rd_acc_i,
  input  logic wr_acc_i,
  input  logic wbit_i,
  input  logic en_i,
  output logic flag_o,
  output logic arm_o,
  output logic irq_o
);
  logic flag_q, arm_q;
  logic set_evt, clr_sw, clr_any;

  assign set_evt = mode_cap_i ? capt_i : match_i;
  assign clr_sw  = wr_acc_i & arm_q & ~wbit_i;
  assign clr_any = clr_sw | dma_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      // set has priority so no event is lost
      flag_q <= set_evt | (flag_q & ~clr_any);
      if (wr_acc_i || (clr_any && !set_evt)) arm_q <= 1'b0;
      else if (rd_acc_i && flag_q)           arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;
  assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/tifr_regif.sv
module tifr_regif
  import tifr_pkg::*;
#(
  parameter int unsigned N_CH = 3,
  localparam int unsigned DW = 2 * N_CH + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [N_CH-1:0] flag_i,
  output bus_acc_t        acc_o,
  output logic [N_CH-1:0] en_o,
  output logic [N_CH-1:0] wflag_o,
  output logic [DW-1:0]   rdata_o
);
  logic [N_CH-1:0] en_q;

  assign acc_o.rd = sel_i & rd_i;
  assign acc_o.wr = sel_i & wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (acc_o.wr)  en_q <= wdata_i[2*N_CH:N_CH+1];
  end

  assign wflag_o = wdata_i[N_CH-1:0];
  assign en_o    = en_q;
  assign rdata_o = acc_o.rd ? {RSVD_VAL, en_q, RSVD_VAL, flag_i} : '0;
endmodule

// File: rtl/tmr_irq_flag_reg.sv
module tmr_irq_flag_reg
  import tifr_pkg::*;
#(
  parameter int unsigned N_CH = 3,
  localparam int unsigned DW = 2 * N_CH + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [N_CH-1:0] mode_i,
  input  logic [N_CH-1:0] match_i,
  input  logic [N_CH-1:0] capt_i,
  input  logic [N_CH-1:0] dma_ack_i,
  output logic [N_CH-1:0] irq_o,
  output logic [N_CH-1:0] dma_req_o
);
  bus_acc_t        acc;
  logic [N_CH-1:0] en_q, flag_q, arm_q, wflag, irq_w;

  tifr_regif #(.N_CH(N_CH)) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .flag_i  (flag_q),
    .acc_o   (acc),
    .en_o    (en_q),
    .wflag_o (wflag),
    .rdata_o (rdata_o)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tifr_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_cap_i (mode_i[i]),
      .match_i    (match_i[i]),
      .capt_i     (capt_i[i]),
      .dma_ack_i  (dma_ack_i[i]),
      .rd_acc_i   (acc.rd),
      .wr_acc_i   (acc.wr),
      .wbit_i     (wflag[i]),
      .en_i       (en_q[i]),
      .flag_o     (flag_q[i]),
      .arm_o      (arm_q[i]),
      .irq_o      (irq_w[i])
    );
  end

  assign irq_o     = irq_w;
  assign dma_req_o = irq_w;
endmodule

// File: rtl/tifr_chk.sv
module tifr_chk #(
  parameter int unsigned N_CH = 3,
  localparam int unsigned DW = 2 * N_CH + 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sel_i,
  input logic            rd_i,
  input logic            wr_i,
  input logic [DW-1:0]   rdata_o,
  input logic [N_CH-1:0] mode_i,
  input logic [N_CH-1:0] match_i,
  input logic [N_CH-1:0] capt_i,
  input logic [N_CH-1:0] dma_ack_i,
  input logic [N_CH-1:0] irq_o,
  input logic [N_CH-1:0] flag_q,
  input logic [N_CH-1:0] en_q,
  input logic [N_CH-1:0] arm_q
);
  logic [N_CH-1:0] set_w;
  assign set_w = (mode_i & capt_i) | (~mode_i & match_i);

  assert_rsvd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i) |-> (rdata_o[DW-1] && rdata_o[N_CH]));
  assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && rd_i) |-> (rdata_o == '0));

  for (genvar i = 0; i < N_CH; i++) begin : g_a
    assert_no_wr_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_q[i] && !set_w[i]) |=> !flag_q[i]);
    assert_unarmed_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !arm_q[i] && !dma_ack_i[i]) |=> flag_q[i]);
    assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_w[i] && en_q[i] && !(sel_i && wr_i)) |=> irq_o[i]);
    assert_dma_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dma_ack_i[i] && !set_w[i]) |=> !flag_q[i]);
    assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_w[i] |=> flag_q[i]);
  end
endmodule

bind tmr_irq_flag_reg tifr_chk #(.N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .rdata_o   (rdata_o),
  .mode_i    (mode_i),
  .match_i   (match_i),
  .capt_i    (capt_i),
  .dma_ack_i (dma_ack_i),
  .irq_o     (irq_o),
  .flag_q    (flag_q),
  .en_q      (en_q),
  .arm_q     (arm_q)
);

// File: tb/tb_tmr_irq_flag_reg.sv
module tb_tmr_irq_flag_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 0, rd_i = 0, wr_i = 0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] mode_i = '0, match_i = '0, capt_i = '0, dma_ack_i = '0;
  logic [2:0] irq_o, dma_req_o;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [2:0] m_en = '0, m_flag = '0, m_arm = '0;

  always #5 clk_i = ~clk_i;

  tmr_irq_flag_reg dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .mode_i(mode_i), .match_i(match_i),
    .capt_i(capt_i), .dma_ack_i(dma_ack_i), .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic s, input logic r);
    return (s && r) ? {1'b1, m_en, 1'b1, m_flag} : 8'h00;
  endfunction

  // one bus cycle: drive after negedge, check read data, advance model at posedge
  task automatic cyc(input logic s, input logic r, input logic w, input logic [7:0] wd,
                     input logic [2:0] mt, input logic [2:0] cp, input logic [2:0] ak,
                     input string tag);
    logic [2:0] set_v, clr_v, f_n, a_n, e_n;
    sel_i = s; rd_i = r; wr_i = w; wdata_i = wd;
    match_i = mt; capt_i = cp; dma_ack_i = ak;
    #1;
    chk(rdata_o, exp_rd(s, r), (s && r) ? tag : "R12");
    set_v = (mode_i & cp) | (~mode_i & mt);
    for (int i = 0; i < 3; i++) begin
      clr_v[i] = ((s && w) && m_arm[i] && !wd[i]) || ak[i];
      f_n[i]   = set_v[i] || (m_flag[i] && !clr_v[i]);
      if (s && w)                      a_n[i] = 1'b0;
      else if (clr_v[i] && !set_v[i])  a_n[i] = 1'b0;
      else if (s && r && m_flag[i])    a_n[i] = 1'b1;
      else                             a_n[i] = m_arm[i];
    end
    e_n = (s && w) ? wd[6:4] : m_en;
    @(posedge clk_i);
    m_flag = f_n; m_arm = a_n; m_en = e_n;
    #1;
    chk({5'b0, irq_o}, {5'b0, m_flag & m_en}, "R9");
    chk({5'b0, dma_req_o}, {5'b0, m_flag & m_en}, "R10");
    @(negedge clk_i);
    sel_i = 0; rd_i = 0; wr_i = 0; match_i = '0; capt_i = '0; dma_ack_i = '0;
  endtask

  task automatic rd(input string tag);
    cyc(1, 1, 0, 8'h00, 3'b0, 3'b0, 3'b0, tag);
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    cyc(1, 0, 1, d, 3'b0, 3'b0, 3'b0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk({5'b0, irq_o}, 8'h00, "R1");
    sel_i = 1; rd_i = 1; #1;
    chk(rdata_o, 8'h88, "R1");
    sel_i = 0; rd_i = 0;
    rd("R1");
    // R2 R3 R4: write all ones, reserved stay 1, flags stay 0
    wr(8'hFF, "R3");
    sel_i = 1; rd_i = 1; #1;
    chk(rdata_o, 8'hF8, "R4");
    sel_i = 0; rd_i = 0;
    wr(8'h00, "R2");
    rd("R2");
    // R7 compare mode
    mode_i = 3'b000;
    cyc(0, 0, 0, 8'h00, 3'b001, 3'b010, 3'b000, "R7");
    // R5 write 0 without prior read
    wr(8'h00, "R5");
    sel_i = 1; rd_i = 1; #1;
    chk(rdata_o, 8'h89, "R5");
    sel_i = 0; rd_i = 0;
    // R6 read arms, write 1 consumes, then read + write 0 clears
    rd("R6");
    wr(8'h01, "R6");
    wr(8'h00, "R6");
    rd("R6");
    wr(8'h00, "R6");
    sel_i = 1; rd_i = 1; #1;
    chk(rdata_o, 8'h88, "R6");
    sel_i = 0; rd_i = 0;
    // R8 capture mode
    mode_i = 3'b111;
    cyc(0, 0, 0, 8'h00, 3'b010, 3'b100, 3'b000, "R8");
    rd("R8");
    // R9 enable ch2, keep flags
    wr(8'h47, "R9");
    chk({5'b0, irq_o}, 8'h04, "R9");
    // R10 DMA clear
    cyc(0, 0, 0, 8'h00, 3'b000, 3'b000, 3'b100, "R10");
    chk({5'b0, dma_req_o}, 8'h00, "R10");
    // R11 collisions
    cyc(0, 0, 0, 8'h00, 3'b000, 3'b001, 3'b000, "R11");
    rd("R11");
    cyc(1, 0, 1, 8'h00, 3'b000, 3'b001, 3'b000, "R11");
    cyc(0, 0, 0, 8'h00, 3'b000, 3'b010, 3'b010, "R11");
    sel_i = 1; rd_i = 1; #1;
    chk(rdata_o, 8'h8B, "R11");
    sel_i = 0; rd_i = 0;
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic s, r, w;
      logic [7:0] d;
      if (n % 200 == 0) mode_i = 3'($urandom);
      s = ($urandom % 10) < 7;
      r = $urandom % 2;
      w = ($urandom % 3) == 0;
      d = 8'($urandom);
      cyc(s, r, w, d,
          3'($urandom & $urandom), 3'($urandom & $urandom),
          3'($urandom & $urandom & $urandom), "R6");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule